// File: doc/BRIEF.md
# Audio Controller Interrupt Aggregator

This block gathers every interrupt source of a multi-stream audio controller into one 32-bit interrupt-status word and one level-sensitive interrupt line. There are two controller-level sources: the command-response ring (its status bits gated by its two enable bits) and the codec state-change flags (gated by per-codec wake enables). Each stream adds its own per-stream source, where the stream's event flags are gated by the matching enables in that stream's control field.

The status word is combinational and follows the source inputs directly. The interrupt line is registered. It is raised when the global enable is set and at least one status bit at the controller position or a stream position is also enabled in the control word. The summary bit at the top of the status word only reports that some source is active. It does not drive the line, so it can read 1 while the line stays low. Register decoding, write-one-to-clear handling and event generation sit outside this block.

Top module: `audio_irq_aggregator`

## Requirements
- R1: Status bit 30 is 1 when `resp_sts_i & resp_ctl_i` is nonzero. Bit 0 of both inputs is the response interrupt and bit 1 is the overrun interrupt.
- R2: Status bit 30 is also 1 when `codec_sts_i & wake_en_i` is nonzero.
- R3: Status bit n (n < NUM_STREAMS) is 1 when bits [2:0] of stream n's status field ANDed with bits [2:0] of its control field are nonzero. Stream n's field sits at bits [4n+3:4n]. Bit 0 is completion, bit 1 is FIFO error and bit 2 is descriptor error.
- R4: Bit 3 of each stream status field and each stream control field has no effect on the status word or on the line.
- R5: Status bit 31 is 1 exactly when any of bits 30:0 is 1. Bits 29:NUM_STREAMS are always 0.
- R6: One clock edge after the inputs settle, `irq_o` is 1 exactly when `irq_ctl_i[31]` is 1 and `irq_sts_o & irq_ctl_i` has a 1 at bit 30 or at any bit below NUM_STREAMS.
- R7: With `irq_ctl_i[31]` at 0, or with all of bit 30 and the stream bits of `irq_ctl_i` at 0, `irq_o` stays 0 even while status bit 31 is 1.
- R8: `irq_o` is 0 while `rst_ni` is low, whatever the sources are.
- R9: Bits 29:NUM_STREAMS of `irq_ctl_i` have no effect on `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| resp_sts_i | input | 2 | Response-ring status flags (bit0 response, bit1 overrun) |
| resp_ctl_i | input | 2 | Response-ring interrupt enables, same positions |
| codec_sts_i | input | CODEC_W | Codec state-change flags |
| wake_en_i | input | CODEC_W | Per-codec wake enables |
| strm_sts_i | input | 4*NUM_STREAMS | Per-stream status fields |
| strm_ctl_i | input | 4*NUM_STREAMS | Per-stream control fields |
| irq_ctl_i | input | 32 | Interrupt control: bit31 global enable, bit30 controller enable, bits below NUM_STREAMS stream enables |
| irq_sts_o | output | 32 | Computed interrupt-status word |
| irq_o | output | 1 | Registered interrupt line |

## Verification
On every cycle, the assertions check the following:
- the summary bit matches the OR of the lower bits;
- the unused status bits stay zero;
- a cleared global enable, or an empty enabled set, keeps the line low on the next cycle;
- an enabled controller or stream hit raises the line on the next cycle.

Only the bench's scenarios can show which source-and-enable pairs set each bit. Those scenarios also show that the reserved bit 3 of the stream fields and the unused control bits are ignored, and that the line stays low during reset while sources are active.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned CTRL_POS = 30;
  localparam int unsigned GLB_POS  = 31;
  localparam int unsigned RESP_W   = 2;
  localparam int unsigned SFLD_W   = 4;
  // completion, fifo error, descriptor error; bit 3 is not an interrupt source
  localparam logic [SFLD_W-1:0] SFLD_IRQ_MASK = 4'b0111;
  localparam logic [RESP_W-1:0] RESP_IRQ_MASK = 2'b11;
endpackage

// File: rtl/irq_ctrl_src.sv
module irq_ctrl_src
  import audio_irq_pkg::*;
#(
  parameter int unsigned CODEC_W = 15
) (
  input  logic [RESP_W-1:0]  resp_sts_i,
  input  logic [RESP_W-1:0]  resp_ctl_i,
  input  logic [CODEC_W-1:0] codec_sts_i,
  input  logic [CODEC_W-1:0] wake_en_i,
  output logic               hit_o
);
  logic resp_hit, codec_hit;
  assign resp_hit  = |(resp_sts_i & resp_ctl_i & RESP_IRQ_MASK);
  assign codec_hit = |(codec_sts_i & wake_en_i);
  assign hit_o     = resp_hit | codec_hit;
endmodule

// File: rtl/irq_stream_src.sv
module irq_stream_src
  import audio_irq_pkg::*;
(
  input  logic [SFLD_W-1:0] sts_i,
  input  logic [SFLD_W-1:0] ctl_i,
  output logic              hit_o
);
  assign hit_o = |(sts_i & ctl_i & SFLD_IRQ_MASK);
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv
  import audio_irq_pkg::*;
#(
  parameter logic [WORD_W-1:0] LINE_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] sts_i,
  input  logic [WORD_W-1:0] ctl_i,
  output logic              irq_o
);
  logic line_d;
  assign line_d = ctl_i[GLB_POS] & (|(sts_i & ctl_i & LINE_MASK));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= line_d;
  end
endmodule

// File: rtl/audio_irq_aggregator.sv
module audio_irq_aggregator
  import audio_irq_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 8,
  parameter int unsigned CODEC_W     = 15
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [RESP_W-1:0]               resp_sts_i,
  input  logic [RESP_W-1:0]               resp_ctl_i,
  input  logic [CODEC_W-1:0]              codec_sts_i,
  input  logic [CODEC_W-1:0]              wake_en_i,
  input  logic [NUM_STREAMS*SFLD_W-1:0]   strm_sts_i,
  input  logic [NUM_STREAMS*SFLD_W-1:0]   strm_ctl_i,
  input  logic [WORD_W-1:0]               irq_ctl_i,
  output logic [WORD_W-1:0]               irq_sts_o,
  output logic                            irq_o
);
  localparam logic [WORD_W-1:0] STRM_MASK = WORD_W'((64'd1 << NUM_STREAMS) - 64'd1);
  localparam logic [WORD_W-1:0] LINE_MASK = STRM_MASK | (WORD_W'(1) << CTRL_POS);

  logic                   ctrl_hit;
  logic [NUM_STREAMS-1:0] strm_hit;
  logic [WORD_W-1:0]      src_word;

  irq_ctrl_src #(.CODEC_W(CODEC_W)) u_ctrl (
    .resp_sts_i (resp_sts_i),
    .resp_ctl_i (resp_ctl_i),
    .codec_sts_i(codec_sts_i),
    .wake_en_i  (wake_en_i),
    .hit_o      (ctrl_hit)
  );

  for (genvar n = 0; n < NUM_STREAMS; n++) begin : g_strm
    irq_stream_src u_src (
      .sts_i(strm_sts_i[n*SFLD_W +: SFLD_W]),
      .ctl_i(strm_ctl_i[n*SFLD_W +: SFLD_W]),
      .hit_o(strm_hit[n])
    );
  end

  always_comb begin
    src_word                = '0;
    src_word[NUM_STREAMS-1:0] = strm_hit;
    src_word[CTRL_POS]      = ctrl_hit;
    irq_sts_o               = src_word;
    irq_sts_o[GLB_POS]      = |src_word;
  end

  irq_line_drv #(.LINE_MASK(LINE_MASK)) u_line (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sts_i (irq_sts_o),
    .ctl_i (irq_ctl_i),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/audio_irq_aggregator_chk.sv
module audio_irq_aggregator_chk
  import audio_irq_pkg::*;
#(
  parameter int unsigned NUM_STREAMS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] irq_ctl_i,
  input logic [WORD_W-1:0] irq_sts_o,
  input logic              irq_o
);
  localparam logic [WORD_W-1:0] STRM_MASK = WORD_W'((64'd1 << NUM_STREAMS) - 64'd1);
  localparam logic [WORD_W-1:0] UNUSED    = ~(STRM_MASK | (WORD_W'(3) << CTRL_POS));
  localparam logic [WORD_W-1:0] LMASK     = STRM_MASK | (WORD_W'(1) << CTRL_POS);

  assert_glb_summary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_sts_o[GLB_POS] == (|irq_sts_o[GLB_POS-1:0]));

  assert_unused_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_sts_o & UNUSED) == '0);

  assert_glb_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_ctl_i[GLB_POS] |=> !irq_o);

  assert_none_enabled_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_sts_o & irq_ctl_i & LMASK) == '0) |=> !irq_o);

  assert_raise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ctl_i[GLB_POS] && ((irq_sts_o & irq_ctl_i & LMASK) != '0)) |=> irq_o);
endmodule

bind audio_irq_aggregator audio_irq_aggregator_chk #(.NUM_STREAMS(NUM_STREAMS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_ctl_i(irq_ctl_i),
  .irq_sts_o(irq_sts_o),
  .irq_o    (irq_o)
);

// File: tb/audio_irq_aggregator_test.sv
`timescale 1ns/1ps
module audio_irq_aggregator_test;
  localparam int NS = 8;
  localparam int CW = 15;

  logic            clk_i = 0;
  logic            rst_ni = 0;
  logic [1:0]      resp_sts_i = 0, resp_ctl_i = 0;
  logic [CW-1:0]   codec_sts_i = 0, wake_en_i = 0;
  logic [NS*4-1:0] strm_sts_i = 0, strm_ctl_i = 0;
  logic [31:0]     irq_ctl_i = 0;
  logic [31:0]     irq_sts_o;
  logic            irq_o;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  audio_irq_aggregator #(.NUM_STREAMS(NS), .CODEC_W(CW)) uut (.*);

  function automatic logic [31:0] model_sts();
    logic [31:0] s = '0;
    if ((resp_sts_i & resp_ctl_i) != 0) s[30] = 1'b1;
    if ((codec_sts_i & wake_en_i) != 0) s[30] = 1'b1;
    for (int n = 0; n < NS; n++)
      if ((strm_sts_i[n*4 +: 3] & strm_ctl_i[n*4 +: 3]) != 0) s[n] = 1'b1;
    if (s != 0) s[31] = 1'b1;
    return s;
  endfunction

  function automatic logic model_line(logic [31:0] s);
    logic hit = 1'b0;
    if (s[30] && irq_ctl_i[30]) hit = 1'b1;
    for (int n = 0; n < NS; n++)
      if (s[n] && irq_ctl_i[n]) hit = 1'b1;
    return irq_ctl_i[31] && hit;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: inputs already applied, compare after edge
  task automatic step();
    logic [31:0] es;
    logic el;
    es = model_sts();
    el = model_line(es);
    @(posedge clk_i); #2;
    check("R1 R2 R3 R5 status", irq_sts_o, es);
    check("R6 line", {31'b0, irq_o}, {31'b0, el});
  endtask

  task automatic clear_all();
    resp_sts_i = 0; resp_ctl_i = 0; codec_sts_i = 0; wake_en_i = 0;
    strm_sts_i = 0; strm_ctl_i = 0; irq_ctl_i = 0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R8: sources active and enabled during reset
    resp_sts_i = 2'b01; resp_ctl_i = 2'b01; irq_ctl_i = 32'hC000_0000;
    repeat (3) @(posedge clk_i);
    #2 check("R8 line in reset", {31'b0, irq_o}, 32'd0);
    rst_ni = 1;
    step(); // R1 response interrupt, R6 raised
    check("R1 resp status", irq_sts_o, 32'hC000_0000);
    check("R6 resp line", {31'b0, irq_o}, 32'd1);

    clear_all(); resp_sts_i = 2'b10; resp_ctl_i = 2'b01; irq_ctl_i = 32'hC000_00FF;
    step(); check("R1 overrun not enabled", irq_sts_o, 32'h0);

    resp_ctl_i = 2'b10;
    step(); check("R1 overrun enabled", irq_sts_o, 32'hC000_0000);

    clear_all(); codec_sts_i = 15'h4000; wake_en_i = 15'h4000; irq_ctl_i = 32'hC000_0000;
    step(); check("R2 codec wake", irq_sts_o, 32'hC000_0000);
    wake_en_i = 15'h3FFF;
    step(); check("R2 codec masked", irq_sts_o, 32'h0);

    clear_all(); strm_sts_i[5*4 +: 4] = 4'b0010; strm_ctl_i[5*4 +: 4] = 4'b0010;
    irq_ctl_i = 32'h8000_0020;
    step(); check("R3 stream5 fifo error", irq_sts_o, 32'h8000_0020);
    check("R6 stream5 line", {31'b0, irq_o}, 32'd1);

    clear_all(); strm_sts_i[2*4 +: 4] = 4'b1000; strm_ctl_i[2*4 +: 4] = 4'b1000;
    irq_ctl_i = 32'hC000_00FF;
    step(); check("R4 reserved stream bit", irq_sts_o, 32'h0);
    check("R4 reserved bit line", {31'b0, irq_o}, 32'd0);

    clear_all(); strm_sts_i = '1; strm_ctl_i = '1; resp_sts_i = 2'b11; resp_ctl_i = 2'b11;
    irq_ctl_i = 32'h4000_00FF;
    step(); check("R7 global off status", irq_sts_o, 32'hC000_00FF);
    check("R7 global off line", {31'b0, irq_o}, 32'd0);
    irq_ctl_i = 32'h8000_0000;
    step(); check("R7 no enables line", {31'b0, irq_o}, 32'd0);

    clear_all(); strm_sts_i[7*4 +: 4] = 4'b0100; strm_ctl_i[7*4 +: 4] = 4'b0100;
    irq_ctl_i = 32'hBFFF_FF00;
    step(); check("R9 unused ctl bits line", {31'b0, irq_o}, 32'd0);
    irq_ctl_i = 32'h8000_0080;
    step(); check("R6 last stream line", {31'b0, irq_o}, 32'd1);
    irq_ctl_i = 32'h0000_0080;
    step(); check("R7 line falls", {31'b0, irq_o}, 32'd0);

    // random traffic against the reference model
    for (int i = 0; i < 3000; i++) begin
      resp_sts_i  = 2'($urandom);
      resp_ctl_i  = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      codec_sts_i = CW'($urandom) & CW'($urandom) & CW'($urandom);
      wake_en_i   = CW'($urandom) & CW'($urandom);
      strm_sts_i  = 32'($urandom) & 32'($urandom) & 32'($urandom);
      strm_ctl_i  = 32'($urandom) & 32'($urandom);
      irq_ctl_i   = 32'($urandom);
      step();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule